// File: doc/BRIEF.md
# Iterative Multi-Cycle Shifter

This block performs the three shift operations of a small 32-bit RISC integer core: logical left, logical right and arithmetic right. It does not use a single-cycle barrel shifter. It keeps the operand in one register and moves it a little on each clock until the requested distance is covered. On any cycle the register moves by exactly four positions or by exactly one position. Four-position steps are taken while four or more positions remain. One-position steps finish the last zero to three positions.

The core pulses a start strobe together with the operand, a 5-bit distance and an operation code. The block raises busy while it works. It signals the end with a one-cycle done pulse, and the result appears at the same time. The result then stays unchanged until the next accepted start. The number of clock cycles is the distance divided by four plus the distance modulo four. The longest case, a distance of 31, takes ten stepping cycles.

Top module: `iter_shifter`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are low and the result is all zeros until a start is accepted.
- R2: A start with a distance of 0 is answered by done on the first clock edge that samples the start. The result equals the operand and busy never rises.
- R3: Operation code 0 (logical left) returns the operand moved toward bit 31 by the distance, with zeros entering at bit 0.
- R4: Operation code 1 (logical right) returns the operand moved toward bit 0 by the distance, with zeros entering at bit 31.
- R5: Operation code 2 (arithmetic right) moves the operand toward bit 0 and fills every vacated upper bit with the original bit 31.
- R6: Each stepping cycle reduces the remaining distance by 4 if at least 4 remain, otherwise by 1. Done therefore arrives distance/4 + distance%4 clock edges after the edge that accepts the start.
- R7: A distance of 31 keeps busy high for exactly 10 cycles, and no operation keeps it high longer.
- R8: Busy is high from the accepting edge until the done edge. Done is a single-cycle pulse that coincides with busy being low.
- R9: A start presented while busy is high is ignored. It changes neither the operation in progress nor its result, and it produces no additional done pulse.
- R10: After done, the result holds its value while no start is presented.
- R11: Operation code 3 behaves exactly as logical right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request strobe, accepted only while busy_o is low |
| operand_i | input | 32 | Value to be shifted, sampled on the accepting edge |
| amount_i | input | 5 | Shift distance 0 to 31, sampled on the accepting edge |
| op_i | input | 2 | Operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 logical right |
| busy_o | output | 1 | High while steps remain |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Shift result, valid with done and held afterwards |

## Verification
The embedded properties assume that operand, distance and operation code are only meaningful on a cycle where start is high and busy is low. They also assume that start may be held or pulsed at any time, including while busy, since such requests must simply fall away. The driver only presents new work after it sees busy low at a falling edge. It separately pulses start with unrelated operands in the middle of a long shift, to test that these requests are ignored. Start is never asserted while reset is low, so every property begins from a clean idle state.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SOP_SLL   = 2'd0,
    SOP_SRL   = 2'd1,
    SOP_SRA   = 2'd2,
    SOP_SRL_B = 2'd3
  } sop_e;

  typedef struct packed {
    logic to_left;
    logic sign_fill;
  } sdir_t;

  function automatic sdir_t decode_op(input logic [1:0] code);
    sdir_t d;
    d.to_left   = (code == SOP_SLL);
    d.sign_fill = (code == SOP_SRA);
    return d;
  endfunction

endpackage

// File: rtl/shf_reset_sync.sv
module shf_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/shf_step_unit.sv
module shf_step_unit #(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             to_left_i,
  input  logic             sign_fill_i,
  input  logic             big_i,
  output logic [WIDTH-1:0] data_o
);

  logic             fill_bit;
  logic [WIDTH-1:0] small_left, small_right;
  logic [WIDTH-1:0] big_left, big_right;

  assign fill_bit    = sign_fill_i & data_i[WIDTH-1];
  assign small_left  = {data_i[WIDTH-2:0], 1'b0};
  assign small_right = {fill_bit, data_i[WIDTH-1:1]};

  generate
    if (BIG_STEP > 1) begin : g_big
      assign big_left  = {data_i[WIDTH-1-BIG_STEP:0], {BIG_STEP{1'b0}}};
      assign big_right = {{BIG_STEP{fill_bit}}, data_i[WIDTH-1:BIG_STEP]};
    end else begin : g_unit
      assign big_left  = small_left;
      assign big_right = small_right;
    end
  endgenerate

  always_comb begin
    if (big_i) data_o = to_left_i ? big_left : big_right;
    else       data_o = to_left_i ? small_left : small_right;
  end

endmodule

// File: rtl/shf_step_ctrl.sv
module shf_step_ctrl #(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [$clog2(WIDTH)-1:0]   amount_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       load_o,
  output logic                       step_o,
  output logic                       big_o
);

  localparam int AMT_W     = $clog2(WIDTH);
  localparam int MAX_STEPS = (WIDTH - 1) / BIG_STEP + (WIDTH - 1) % BIG_STEP;
  localparam int RUN_W     = $clog2(MAX_STEPS + 2);
  localparam logic [AMT_W-1:0] BIG_AMT = AMT_W'(BIG_STEP);
  localparam logic [AMT_W-1:0] ONE_AMT = AMT_W'(1);

  logic [AMT_W-1:0] rem_q, rem_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             state_en;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign big_o  = (rem_q >= BIG_AMT);

  always_comb begin
    rem_d  = rem_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load_o) begin
      rem_d  = amount_i;
      busy_d = (amount_i != '0);
      done_d = (amount_i == '0);
    end else if (busy_q) begin
      rem_d  = rem_q - (big_o ? BIG_AMT : ONE_AMT);
      busy_d = (rem_d != '0);
      done_d = (rem_d == '0);
    end
  end

  assign state_en = load_o | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (state_en) begin
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // Checker-only run length counter for the latency bound
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q && amount_i == '0) |=> (done_q && !busy_q)); // R2

  AST_BIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q >= BIG_AMT) |=> (rem_q == $past(rem_q) - BIG_AMT)); // R6

  AST_SMALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rem_q < BIG_AMT) |=> (rem_q == $past(rem_q) - ONE_AMT)); // R6

  AST_BOUNDED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_q < RUN_W'(MAX_STEPS))); // R7

  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $fell(busy_q) == 1'b0) |=> (busy_q || done_q)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R8

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (rem_q < $past(rem_q))); // R9

endmodule

// File: rtl/iter_shifter.sv
module iter_shifter #(
  parameter int WIDTH    = 32,
  parameter int BIG_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [WIDTH-1:0]         operand_i,
  input  logic [$clog2(WIDTH)-1:0] amount_i,
  input  logic [1:0]               op_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [WIDTH-1:0]         result_o
);

  import shifter_pkg::*;

  logic             rst_n_int;
  logic             load, step, big;
  logic [WIDTH-1:0] data_q, data_d, stepped;
  sdir_t            dir_q, dir_d;
  logic             data_en;

  shf_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  shf_step_ctrl #(.WIDTH(WIDTH), .BIG_STEP(BIG_STEP)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .amount_i (amount_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .load_o   (load),
    .step_o   (step),
    .big_o    (big)
  );

  shf_step_unit #(.WIDTH(WIDTH), .BIG_STEP(BIG_STEP)) u_step (
    .data_i      (data_q),
    .to_left_i   (dir_q.to_left),
    .sign_fill_i (dir_q.sign_fill),
    .big_i       (big),
    .data_o      (stepped)
  );

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (load) begin
      data_d = operand_i;
      dir_d  = decode_op(op_i);
    end else if (step) begin
      data_d = stepped;
    end
  end

  assign data_en = load | step;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (data_en) begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end

  assign result_o = data_q;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!busy_o && !start_i) |=> $stable(result_o)); // R10

  AST_IGNORE_OPERAND: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy_o |=> $stable(dir_q)); // R9

endmodule

// File: tb/iter_shifter_test.sv
`timescale 1ns/1ps
module iter_shifter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [4:0]  amount_i = '0;
  logic [1:0]  op_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;
  logic [31:0] last_exp = '0;

  logic [31:0] q_res[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iter_shifter uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .amount_i(amount_i), .op_i(op_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a, input int n);
    case (op)
      2'd0:    return a << n;
      2'd2:    return 32'($signed(a) >>> n);
      default: return a >> n;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input int n, input string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    op_i = op; operand_i = a; amount_i = 5'(n); start_i = 1'b1;
    q_res.push_back(model(op, a, n));
    q_cyc.push_back(cyc + 1 + n / 4 + n % 4);
    q_tag.push_back(tag);
    last_exp = model(op, a, n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: pops expected items when done appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done_o) begin
        if (q_res.size() == 0) begin
          chk(1'b0, "R9 unexpected done", result_o, 32'h0);
        end else begin
          logic [31:0] er;
          int ec;
          string tg;
          er = q_res.pop_front(); ec = q_cyc.pop_front(); tg = q_tag.pop_front();
          chk(result_o === er, tg, result_o, er);
          chk(cyc == ec, {"R6 latency ", tg}, 32'(cyc), 32'(ec));
          chk(busy_o === 1'b0, "R8 busy with done", {31'b0, busy_o}, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && result_o === 32'h0, "R1 reset state",
        {busy_o, done_o, result_o[29:0]}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && result_o === 32'h0, "R1 after release",
        {busy_o, done_o, result_o[29:0]}, 32'h0);

    // R2: zero distance, busy must stay low
    issue(2'd2, 32'h8765_4321, 0, "R2 zero distance");
    chk(busy_o === 1'b0, "R2 busy stayed low", {31'b0, busy_o}, 32'h0);
    issue(2'd0, 32'hFFFF_0001, 0, "R2 zero distance left");

    issue(2'd0, 32'h0000_0001, 31, "R3 left 31");
    issue(2'd0, 32'hA5A5_A5A5, 5,  "R3 left 5");
    issue(2'd1, 32'h8000_0000, 31, "R4 right 31");
    issue(2'd1, 32'hF0F0_F0F0, 7,  "R4 right 7");
    issue(2'd2, 32'h8000_0000, 31, "R5 arith neg 31");
    issue(2'd2, 32'h9000_00F0, 6,  "R5 arith neg 6");
    issue(2'd2, 32'h7FFF_FFFF, 9,  "R5 arith pos 9");
    issue(2'd3, 32'hC000_0003, 13, "R11 code three");

    // R6: every distance for every code
    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 32; n++) begin
        issue(2'(op), 32'hB3C4_5D6E ^ (32'(n) << 9), n, "R6 sweep");
      end
    end

    // R7: busy duration at the longest distance
    issue(2'd2, 32'hDEAD_BEEF, 31, "R7 worst case");
    begin
      int busy_cnt = 0;
      while (busy_o) begin busy_cnt++; @(negedge clk); end
      chk(busy_cnt == 10, "R7 busy cycles", 32'(busy_cnt), 32'd10);
    end

    // R9: starts during busy are ignored
    issue(2'd1, 32'h1234_5678, 31, "R9 kept operation");
    op_i = 2'd0; operand_i = 32'hFFFF_FFFF; amount_i = 5'd0; start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    wait (q_res.size() == 0);

    // R10: result held after done
    repeat (6) @(negedge clk);
    chk(result_o === last_exp, "R10 result held", result_o, last_exp);
    chk(done_o === 1'b0, "R8 single pulse", {31'b0, done_o}, 32'h0);

    wait (q_res.size() == 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule